// File: doc/BRIEF.md
# Programmable Interrupt Router

This block gathers two groups of sixteen level-sensitive interrupt sources and steers each one to one of five CPU interrupt lines. Every group has a live pending view, which is simply the current level of its sources, and a mask in which a 1 enables a source. A source takes part in routing only while it is both pending and enabled.

Some pins own a 3-bit route code kept in one of four assignment words. Each word holds up to five fields. A pin without a field always goes to line 0. Software reaches the masks, the assignment words and a per-line status word through a small word-wide register bus. Writes are synchronous and reads are combinational. Each line's status word names the lowest-numbered active source routed there, and it searches group 1 before group 2.

Top module: `irq_router`

## Requirements
- R1: Address 0 reads the group 1 source levels and address 2 reads the group 2 source levels. A write to either address changes no state.
- R2: Address 1 holds the group 1 mask and address 3 holds the group 2 mask. Both are read/write, and both reset to 0.
- R3: A source is active only while its level is 1 and its mask bit is 1. An enabled source at level 0 drives nothing, and a disabled source at level 1 drives nothing.
- R4: Addresses 4 to 7 are the assignment words.
  - Fields are 3 bits wide and sit at bit offsets 0, 3, 6, 9 and 12.
  - Word 4 covers group 1 pins 0, 1, 2, 3 and 8.
  - Word 5 covers group 1 pin 9 at offset 0, pin 11 at offset 6 and pin 12 at offset 9.
  - Word 6 covers group 2 pins 0, 1, 3, 4 and 5.
  - Word 7 covers group 2 pins 6, 7, 8, 9 and 10.
  - Code n (0 to 4) selects line n.
- R5: After reset, group 1 pin 2 routes to line 1 and group 2 pin 0 routes to line 2. Every other source routes to line 0. Word 4 therefore reads 0x0040 and word 6 reads 0x0002.
- R6: When a field in a write carries code 5, 6 or 7, that field keeps its old value. Valid fields in the same write still update.
- R7: A pin without a field always routes to line 0. A bit position without a field reads 0 and ignores writes.
- R8: `cpu_irq[n]` is the OR of all active sources routed to line n. It is registered, so it reflects the inputs and state of the previous clock.
- R9: Addresses 8 to 12 give the status of lines 0 to 4.
  - Bit 15 is the valid bit.
  - Bits 4:0 give the source index: bit 4 is the group (0 means group 1) and bits 3:0 are the pin.
  - The index names the lowest pin of group 1 that is active on that line, or failing that, the lowest such pin of group 2.
  - The word is 0 when no source is active on the line.
- R10: Addresses 13 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 16 | Group 1 source levels |
| src_b | input | 16 | Group 2 source levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| cpu_irq | output | 5 | Registered CPU interrupt lines 0 to 4 |

## Verification
On every cycle, the assertions check four things:
- both masks come out of reset cleared;
- a write to a pending address disturbs no mask or route;
- no stored route code ever exceeds 4;
- each line's status valid bit predicts that line's output one clock later, and the lines stay quiet after a cycle with both masks clear.

Only the bench scenarios can show the routing itself:
- the exact field-to-pin placement;
- the handling of mixed valid and invalid codes in one write;
- the fixed route of pins without a field;
- the group-first, lowest-pin search order.

The bench covers these by comparing every output and read against a behavioural model.

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router #(
  parameter int SRC_W  = 16,
  parameter int N_OUT  = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       src_a,
  input  logic [15:0]       src_b,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [4:0]        cpu_irq
);
  localparam int NFLD = 5;
  localparam logic [19:0] FLD_EN = {5'b11111, 5'b11111, 5'b01101, 5'b11111};

  logic [15:0] mask_a, mask_b;
  logic [15:0] asg [4];
  logic [CODE_W-1:0] rt_a [SRC_W];
  logic [CODE_W-1:0] rt_b [SRC_W];
  logic [15:0] act_a, act_b;
  logic [4:0]  irq_d, st_vld;
  logic [4:0]  st_idx [N_OUT];

  assign act_a = src_a & mask_a;
  assign act_b = src_b & mask_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a  <= '0;
      mask_b  <= '0;
      asg[0]  <= 16'h0040;
      asg[1]  <= '0;
      asg[2]  <= 16'h0002;
      asg[3]  <= '0;
      cpu_irq <= '0;
    end else begin
      cpu_irq <= irq_d;
      if (reg_we) begin
        if (reg_addr == 4'd1) mask_a <= reg_wdata;
        if (reg_addr == 4'd3) mask_b <= reg_wdata;
        if (reg_addr[3:2] == 2'b01)
          for (int k = 0; k < NFLD; k++)
            if (FLD_EN[reg_addr[1:0]*NFLD + k] && reg_wdata[k*3 +: 3] <= 3'd4)
              asg[reg_addr[1:0]][k*3 +: 3] <= reg_wdata[k*3 +: 3];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < SRC_W; p++) begin
      rt_a[p] = '0;
      rt_b[p] = '0;
    end
    rt_a[0]  = asg[0][2:0];   rt_a[1]  = asg[0][5:3];   rt_a[2] = asg[0][8:6];
    rt_a[3]  = asg[0][11:9];  rt_a[8]  = asg[0][14:12];
    rt_a[9]  = asg[1][2:0];   rt_a[11] = asg[1][8:6];   rt_a[12] = asg[1][11:9];
    rt_b[0]  = asg[2][2:0];   rt_b[1]  = asg[2][5:3];   rt_b[3] = asg[2][8:6];
    rt_b[4]  = asg[2][11:9];  rt_b[5]  = asg[2][14:12];
    rt_b[6]  = asg[3][2:0];   rt_b[7]  = asg[3][5:3];   rt_b[8] = asg[3][8:6];
    rt_b[9]  = asg[3][11:9];  rt_b[10] = asg[3][14:12];
  end

  always_comb begin
    irq_d = '0;
    for (int n = 0; n < N_OUT; n++)
      for (int p = 0; p < SRC_W; p++)
        if ((act_a[p] && rt_a[p] == 3'(n)) || (act_b[p] && rt_b[p] == 3'(n)))
          irq_d[n] = 1'b1;
  end

  always_comb begin
    st_vld = '0;
    for (int n = 0; n < N_OUT; n++) begin
      st_idx[n] = '0;
      for (int p = SRC_W-1; p >= 0; p--)
        if (act_b[p] && rt_b[p] == 3'(n)) begin
          st_vld[n] = 1'b1;
          st_idx[n] = {1'b1, 4'(p)};
        end
      for (int p = SRC_W-1; p >= 0; p--)
        if (act_a[p] && rt_a[p] == 3'(n)) begin
          st_vld[n] = 1'b1;
          st_idx[n] = {1'b0, 4'(p)};
        end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0: reg_rdata = src_a;
      4'd1: reg_rdata = mask_a;
      4'd2: reg_rdata = src_b;
      4'd3: reg_rdata = mask_b;
      4'd4, 4'd5, 4'd6, 4'd7: reg_rdata = asg[reg_addr[1:0]];
      4'd8, 4'd9, 4'd10, 4'd11, 4'd12:
        reg_rdata = {st_vld[reg_addr - 4'd8], 10'b0, st_idx[reg_addr - 4'd8]};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [15:0] mask_a,
  input logic [15:0] mask_b,
  input logic [63:0] asg_all,
  input logic [4:0]  cpu_irq,
  input logic [4:0]  st_vld
);
  assert_mask_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_a == 16'h0 && mask_b == 16'h0));

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_a == 16'h0 && mask_b == 16'h0) |=> (cpu_irq == 5'b0));

  assert_pend_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == 4'd0 || reg_addr == 4'd2)) |=>
      ($stable(mask_a) && $stable(mask_b) && $stable(asg_all)));

  assert_status_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(st_vld)));

  for (genvar f = 0; f < 20; f++) begin : g_code
    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      asg_all[(f/5)*16 + (f%5)*3 +: 3] <= 3'd4);
  end
endmodule

bind irq_router irq_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .mask_a(mask_a), .mask_b(mask_b),
  .asg_all({asg[3], asg[2], asg[1], asg[0]}),
  .cpu_irq(cpu_irq), .st_vld(st_vld)
);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] src_a = '0, src_b = '0, reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_rdata;
  logic [4:0] cpu_irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_router u0 (.clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq));

  int rt [2][16];
  logic [15:0] mm [2];
  logic [4:0] exp_irq;

  function automatic int fpin(int w, int k);
    case (w)
      0: case (k) 0: return 0; 1: return 1; 2: return 2; 3: return 3; default: return 8; endcase
      1: case (k) 0: return 9; 2: return 11; 3: return 12; default: return -1; endcase
      2: case (k) 0: return 0; 1: return 1; 2: return 3; 3: return 4; default: return 5; endcase
      default: return 6 + k;
    endcase
  endfunction

  function automatic logic [15:0] lvl(int g);
    return g == 0 ? src_a : src_b;
  endfunction

  function automatic logic [4:0] m_irq();
    logic [4:0] r = '0;
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 16; p++)
        if (lvl(g)[p] && mm[g][p]) r[rt[g][p]] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] m_read(logic [3:0] a);
    logic [15:0] v = '0;
    if (a == 0) return src_a;
    if (a == 2) return src_b;
    if (a == 1) return mm[0];
    if (a == 3) return mm[1];
    if (a >= 4 && a <= 7) begin
      for (int k = 0; k < 5; k++)
        if (fpin(a - 4, k) >= 0) v |= 16'(rt[(a - 4) / 2][fpin(a - 4, k)]) << (3 * k);
      return v;
    end
    if (a >= 8 && a <= 12) begin
      for (int g = 0; g < 2; g++)
        for (int p = 0; p < 16; p++)
          if (v == 0 && lvl(g)[p] && mm[g][p] && rt[g][p] == a - 8)
            v = 16'h8000 | 16'(g * 16 + p);
      return v;
    end
    return 16'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) for (int p = 0; p < 16; p++) rt[g][p] = 0;
      rt[0][2] = 1; rt[1][0] = 2;
      mm[0] = '0; mm[1] = '0;
      exp_irq = '0;
    end else begin
      exp_irq = m_irq();
      if (reg_we) begin
        if (reg_addr == 1) mm[0] = reg_wdata;
        if (reg_addr == 3) mm[1] = reg_wdata;
        if (reg_addr >= 4 && reg_addr <= 7)
          for (int k = 0; k < 5; k++)
            if (fpin(reg_addr - 4, k) >= 0 && ((reg_wdata >> (3 * k)) & 7) <= 4)
              rt[(reg_addr - 4) / 2][fpin(reg_addr - 4, k)] = int'((reg_wdata >> (3 * k)) & 7);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string atag(logic [3:0] a);
    if (a == 0 || a == 2) return "R1";
    if (a == 1 || a == 3) return "R2";
    if (a <= 7) return "R4";
    if (a <= 12) return "R9";
    return "R10";
  endfunction

  task automatic cyc(logic we, logic [3:0] a, logic [15:0] d, logic [15:0] sa, logic [15:0] sb);
    reg_we = we; reg_addr = a; reg_wdata = d; src_a = sa; src_b = sb;
    @(posedge clk); @(negedge clk);
    chk("R8", 16'(cpu_irq), 16'(exp_irq));
    chk(atag(a), reg_rdata, m_read(a));
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", 16'(cpu_irq), 16'h0);
    reg_addr = 4'd4; #1 chk("R5", reg_rdata, 16'h0040);
    reg_addr = 4'd6; #1 chk("R5", reg_rdata, 16'h0002);
    reg_addr = 4'd1; #1 chk("R2", reg_rdata, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 16; a++) cyc(0, 4'(a), 0, 16'h1234, 16'hABCD);
    cyc(0, 4'd13, 0, 0, 0); chk("R10", reg_rdata, 16'h0);

    cyc(0, 4'd8, 0, 16'hFFFF, 16'hFFFF); chk("R3", 16'(cpu_irq), 16'h0);
    cyc(1, 4'd1, 16'h0010, 16'h0000, 0);
    cyc(0, 4'd8, 0, 16'h0000, 0); chk("R3", 16'(cpu_irq), 16'h0);
    cyc(0, 4'd8, 0, 16'h0010, 0);
    cyc(0, 4'd8, 0, 16'h0010, 0); chk("R7", 16'(cpu_irq), 16'h0001);
    chk("R9", reg_rdata, 16'h8004);

    cyc(1, 4'd4, 16'h007B, 0, 0);
    chk("R6", reg_rdata, 16'h0043);
    cyc(1, 4'd5, 16'h2492, 0, 0);
    chk("R7", reg_rdata, 16'h0482);
    cyc(1, 4'd5, 16'hFFFF, 0, 0);
    chk("R6", reg_rdata, 16'h0482);

    cyc(1, 4'd6, 16'h0100, 0, 0);
    cyc(1, 4'd3, 16'h0008, 0, 16'h0008);
    cyc(0, 4'd12, 0, 0, 16'h0008);
    chk("R4", 16'(cpu_irq), 16'h0010);
    chk("R9", reg_rdata, 16'h8013);

    cyc(1, 4'd0, 16'hFFFF, 0, 0);
    cyc(1, 4'd2, 16'hFFFF, 0, 0);
    cyc(0, 4'd1, 0, 0, 0); chk("R1", reg_rdata, 16'h0010);
    cyc(0, 4'd4, 0, 0, 0); chk("R1", reg_rdata, 16'h0043);

    for (int i = 0; i < 600; i++)
      cyc(($urandom % 3) == 0, 4'($urandom % 16), 16'($urandom),
          16'($urandom & $urandom), 16'($urandom & $urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule